// File: doc/BRIEF.md
# Bridge Translation Control Register

This block is the 32-bit control and status word of a two-sided (primary and secondary) bridge address translation unit. Software writes and reads it over a simple local register bus that has per-byte write enables. The block turns the stored bits into four kinds of behaviour. It produces one-clock error strobes on active-low lines, one per side. It moves outbound addresses into the upper half of the address space. It applies a per-side rule that loosens read-command matching for delayed read completions. It keeps a sticky status flag that is set when any of three discard timers reports an expiry.

The outbound remap and the command-match decision are purely combinational. They sit in the paths of the surrounding translation logic and add no cycle of latency, so those paths carry no valid/ready handshake. The register bus, the error strobes and the status inputs are plain control pins. Bit positions are fixed because software depends on them.

Top module: `xlat_ctl_reg`

## Requirements
- R1: After reset, `reg_rdata` reads 0, both `pri_serr_n` and `sec_serr_n` are 1, `fn_swap` is 0, and `ob_addr_out` equals `ob_addr_in`.
- R2: Bits 31:22 and 14:13 always read 0 and ignore writes. Bits 21:16 and 12:0 are read/write, so writing all ones with every byte enabled reads back 0x003F_1FFF.
- R3: A write changes only the byte lanes whose `reg_be` bit is 1 (lane n covers bits 8n+7:8n). The other lanes keep their value.
- R4: When bit 16 goes from 0 to 1, `pri_serr_n` goes low for exactly one clock. The low cycle starts on the second rising edge after the write is taken, and `sec_serr_n` stays high.
- R5: Bit 17 does the same on `sec_serr_n`, and `pri_serr_n` stays high.
- R6: Writing 1 to an error-assert bit that is already 1 produces no further pulse. After software clears the bit, a later set produces one new pulse.
- R7: When bit 18 and bit 7 are both 1, any `ob_addr_in` from 0x0000_2000 to 0x7FFF_FFFF leaves on `ob_addr_out` with bit 31 forced to 1. The other bits are unchanged.
- R8: `ob_addr_out` equals `ob_addr_in` when bit 18 is 0, when bit 7 is 0, when the address is below 0x0000_2000, or when bit 31 of the address is already 1.
- R9: `dr_hit` is 1 only when `dr_valid` and `dr_addr_hit` are both 1 and either `dr_cur_cmd` equals `dr_req_cmd` or the alias bit of the selected side is 1.
- R10: The alias bit is bit 19 for the primary side (`dr_side`=0) and bit 20 for the secondary side (`dr_side`=1). The alias bit of the side that is not selected has no effect.
- R11: Bit 15 reads 1 from the cycle after any of the three `tmr_expired` inputs is 1, and it stays 1 after the inputs drop.
- R12: Writing 1 to bit 15 (lane 1 enabled) clears it. Writing 0 leaves it set. If an expiry arrives in the same cycle as the clear, the bit stays 1.
- R13: Bit 21 is read/write and drives `fn_swap` as a level output. Bit 7 is read/write and reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe, taken at the rising edge |
| reg_be | input | 4 | Per-byte write enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register value, with reserved bits at 0 |
| tmr_expired | input | 3 | Discard-timer expiry flags |
| pri_serr_n | output | 1 | Primary-side active-low error strobe |
| sec_serr_n | output | 1 | Secondary-side active-low error strobe |
| ob_addr_in | input | 32 | Outbound address before remap |
| ob_addr_out | output | 32 | Outbound address after remap |
| dr_valid | input | 1 | Delayed-read comparison request |
| dr_side | input | 1 | 0 = primary side, 1 = secondary side |
| dr_cur_cmd | input | 4 | Read command of the current transaction |
| dr_req_cmd | input | 4 | Read command of the stored delayed request |
| dr_addr_hit | input | 1 | Address of the current read matches the stored request |
| dr_hit | output | 1 | Current read may take the buffered data |
| fn_swap | output | 1 | Function-number swap select (level) |

## Verification
The assertions assume that the register bus holds its inputs stable across each sampling edge and that `reg_rdata` is the only view of the stored bits. The stickiness checks also assume that a clear of bit 15 arrives only through a lane-1 write. The bench drives every input on the falling edge and keeps the expiry inputs and the bus writes one cycle wide. It overlaps an expiry with a clear only in the one scenario that exercises the priority between them. Error-assert bits are always cleared and left idle for a cycle before the next scenario begins, so no pulse from one scenario spills into another.

// File: rtl/xlat_ctl_pkg.sv
package xlat_ctl_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned LANES   = REG_W / 8;
  localparam int unsigned N_SIDES = 2;
  localparam int unsigned N_TMR   = 3;
  localparam int unsigned CMD_W   = 4;

  localparam int unsigned B_DIR_EN  = 7;
  localparam int unsigned B_DISCARD = 15;
  localparam int unsigned B_PERR    = 16;
  localparam int unsigned B_SERR    = 17;
  localparam int unsigned B_UPPER   = 18;
  localparam int unsigned B_PALIAS  = 19;
  localparam int unsigned B_SALIAS  = 20;
  localparam int unsigned B_FNSWAP  = 21;

  // plain read/write storage; bit 15 is handled apart as write-one-to-clear
  localparam logic [REG_W-1:0] RW_MASK = 32'h003F_1FFF;

  typedef enum logic {SIDE_PRI = 1'b0, SIDE_SEC = 1'b1} side_e;

  typedef struct packed {
    logic                fn_swap;
    logic [N_SIDES-1:0]  alias_en;
    logic                upper_en;
    logic [N_SIDES-1:0]  serr_req;
    logic                dir_en;
  } ctl_t;
endpackage

// File: rtl/xcr_regfile.sv
module xcr_regfile
  import xlat_ctl_pkg::*;
#(
  parameter int unsigned NUM_TMR = N_TMR
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [LANES-1:0]   be,
  input  logic [REG_W-1:0]   wdata,
  input  logic [NUM_TMR-1:0] tmr_expired,
  output logic [REG_W-1:0]   rdata,
  output ctl_t               ctl
);
  localparam int unsigned DISC_LANE = B_DISCARD / 8;

  logic [REG_W-1:0] rw_q;
  logic             disc_q;
  logic             disc_set;
  logic             disc_clr;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rw_q[ln*8 +: 8] <= '0;
      end else if (wr_en && be[ln]) begin
        rw_q[ln*8 +: 8] <= wdata[ln*8 +: 8] & RW_MASK[ln*8 +: 8];
      end
    end
  end

  assign disc_set = |tmr_expired;
  assign disc_clr = wr_en && be[DISC_LANE] && wdata[B_DISCARD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disc_q <= 1'b0;
    end else begin
      disc_q <= disc_set | (disc_q & ~disc_clr);
    end
  end

  always_comb begin
    rdata            = rw_q & RW_MASK;
    rdata[B_DISCARD] = disc_q;
  end

  always_comb begin
    ctl.dir_en             = rw_q[B_DIR_EN];
    ctl.serr_req[SIDE_PRI] = rw_q[B_PERR];
    ctl.serr_req[SIDE_SEC] = rw_q[B_SERR];
    ctl.upper_en           = rw_q[B_UPPER];
    ctl.alias_en[SIDE_PRI] = rw_q[B_PALIAS];
    ctl.alias_en[SIDE_SEC] = rw_q[B_SALIAS];
    ctl.fn_swap            = rw_q[B_FNSWAP];
  end
endmodule

// File: rtl/xcr_err_pulse.sv
module xcr_err_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic pulse_n
);
  logic fired_q;
  logic pulse_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q   <= 1'b0;
      pulse_n_q <= 1'b1;
    end else begin
      fired_q   <= req;
      pulse_n_q <= !(req && !fired_q);
    end
  end

  assign pulse_n = pulse_n_q;
endmodule

// File: rtl/xcr_addr_remap.sv
module xcr_addr_remap #(
  parameter int unsigned          ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]    LO_BOUND = 'h2000
) (
  input  logic              dir_en,
  input  logic              upper_en,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  logic in_window;

  assign in_window = (addr_in >= LO_BOUND) && !addr_in[ADDR_W-1];

  always_comb begin
    addr_out = addr_in;
    if (dir_en && upper_en && in_window) begin
      addr_out = {1'b1, addr_in[ADDR_W-2:0]};
    end
  end
endmodule

// File: rtl/xcr_cmd_match.sv
module xcr_cmd_match #(
  parameter int unsigned CMD_BITS  = 4,
  parameter int unsigned NUM_SIDES = 2,
  localparam int unsigned SIDE_W   = (NUM_SIDES > 1) ? $clog2(NUM_SIDES) : 1
) (
  input  logic                 valid,
  input  logic [SIDE_W-1:0]    side,
  input  logic [CMD_BITS-1:0]  cur_cmd,
  input  logic [CMD_BITS-1:0]  req_cmd,
  input  logic                 addr_hit,
  input  logic [NUM_SIDES-1:0] alias_en,
  output logic                 hit
);
  logic cmd_ok;
  logic side_alias;

  assign side_alias = alias_en[side];
  assign cmd_ok     = (cur_cmd == req_cmd) || side_alias;
  assign hit        = valid && addr_hit && cmd_ok;
endmodule

// File: rtl/xlat_ctl_reg.sv
module xlat_ctl_reg
  import xlat_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [LANES-1:0]   reg_be,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [N_TMR-1:0]   tmr_expired,
  output logic               pri_serr_n,
  output logic               sec_serr_n,
  input  logic [REG_W-1:0]   ob_addr_in,
  output logic [REG_W-1:0]   ob_addr_out,
  input  logic               dr_valid,
  input  logic               dr_side,
  input  logic [CMD_W-1:0]   dr_cur_cmd,
  input  logic [CMD_W-1:0]   dr_req_cmd,
  input  logic               dr_addr_hit,
  output logic               dr_hit,
  output logic               fn_swap
);
  ctl_t               ctl;
  logic [N_SIDES-1:0] serr_n;

  xcr_regfile #(.NUM_TMR(N_TMR)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (reg_wr_en),
    .be          (reg_be),
    .wdata       (reg_wdata),
    .tmr_expired (tmr_expired),
    .rdata       (reg_rdata),
    .ctl         (ctl)
  );

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    xcr_err_pulse u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (ctl.serr_req[s]),
      .pulse_n (serr_n[s])
    );
  end

  assign pri_serr_n = serr_n[SIDE_PRI];
  assign sec_serr_n = serr_n[SIDE_SEC];

  xcr_addr_remap #(.ADDR_W(REG_W), .LO_BOUND(32'h0000_2000)) u_remap (
    .dir_en   (ctl.dir_en),
    .upper_en (ctl.upper_en),
    .addr_in  (ob_addr_in),
    .addr_out (ob_addr_out)
  );

  xcr_cmd_match #(.CMD_BITS(CMD_W), .NUM_SIDES(N_SIDES)) u_match (
    .valid    (dr_valid),
    .side     (dr_side),
    .cur_cmd  (dr_cur_cmd),
    .req_cmd  (dr_req_cmd),
    .addr_hit (dr_addr_hit),
    .alias_en (ctl.alias_en),
    .hit      (dr_hit)
  );

  assign fn_swap = ctl.fn_swap;
endmodule

// File: rtl/xcr_checker.sv
module xcr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [3:0]  reg_be,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic [2:0]  tmr_expired,
  input logic        pri_serr_n,
  input logic        sec_serr_n,
  input logic [31:0] ob_addr_in,
  input logic [31:0] ob_addr_out,
  input logic        dr_valid,
  input logic        dr_addr_hit,
  input logic        dr_hit
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[31:22] == 10'd0) && (reg_rdata[14:13] == 2'd0)); // R2

  AST_PRI_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_serr_n |=> pri_serr_n); // R4

  AST_PRI_FROM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pri_serr_n) |-> $past(reg_rdata[16])); // R4

  AST_SEC_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_serr_n |=> sec_serr_n); // R5

  AST_SEC_FROM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_serr_n) |-> $past(reg_rdata[17])); // R5

  AST_PRI_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pri_serr_n && reg_rdata[16]) |=> (pri_serr_n && reg_rdata[16]) |=> pri_serr_n); // R6

  AST_REMAP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[18] && reg_rdata[7] && ob_addr_in >= 32'h2000 && !ob_addr_in[31])
      |-> (ob_addr_out[31] && ob_addr_out[30:0] == ob_addr_in[30:0])); // R7

  AST_REMAP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rdata[18] && reg_rdata[7]) |-> (ob_addr_out == ob_addr_in)); // R8

  AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    dr_hit |-> (dr_valid && dr_addr_hit)); // R9

  AST_DISCARD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|tmr_expired) |=> reg_rdata[15]); // R11

  AST_DISCARD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15] && !(reg_wr_en && reg_be[1] && reg_wdata[15])) |=> reg_rdata[15]); // R12
endmodule

bind xlat_ctl_reg xcr_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_be      (reg_be),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .tmr_expired (tmr_expired),
  .pri_serr_n  (pri_serr_n),
  .sec_serr_n  (sec_serr_n),
  .ob_addr_in  (ob_addr_in),
  .ob_addr_out (ob_addr_out),
  .dr_valid    (dr_valid),
  .dr_addr_hit (dr_addr_hit),
  .dr_hit      (dr_hit)
);

// File: tb/sim_xlat_ctl_reg.sv
module sim_xlat_ctl_reg;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  tmr_expired = '0;
  logic        pri_serr_n, sec_serr_n;
  logic [31:0] ob_addr_in = '0;
  logic [31:0] ob_addr_out;
  logic        dr_valid = 1'b0, dr_side = 1'b0, dr_addr_hit = 1'b0;
  logic [3:0]  dr_cur_cmd = '0, dr_req_cmd = '0;
  logic        dr_hit, fn_swap;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_ctl_reg u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_expired(tmr_expired),
    .pri_serr_n(pri_serr_n), .sec_serr_n(sec_serr_n),
    .ob_addr_in(ob_addr_in), .ob_addr_out(ob_addr_out),
    .dr_valid(dr_valid), .dr_side(dr_side), .dr_cur_cmd(dr_cur_cmd),
    .dr_req_cmd(dr_req_cmd), .dr_addr_hit(dr_addr_hit), .dr_hit(dr_hit),
    .fn_swap(fn_swap)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] be, logic [31:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_be = be; reg_wdata = data;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_be = '0; reg_wdata = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    ob_addr_in = 32'h1234_5678;
    #1;
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 pri_serr_n", {31'd0, pri_serr_n}, 32'd1);
    chk("R1 sec_serr_n", {31'd0, sec_serr_n}, 32'd1);
    chk("R1 fn_swap", {31'd0, fn_swap}, 32'd0);
    chk("R1 addr pass", ob_addr_out, 32'h1234_5678);
  endtask

  task automatic t_reserved();
    bus_write(4'hF, 32'hFFFF_FFFF);
    chk("R2 all ones readback", reg_rdata, 32'h003F_1FFF);
    bus_write(4'hF, 32'h0);
    chk("R2 cleared", reg_rdata, 32'h0);
    idle(2);
  endtask

  task automatic t_byte_en();
    bus_write(4'b0001, 32'hFFFF_FFFF);
    chk("R3 lane0 only", reg_rdata, 32'h0000_00FF);
    bus_write(4'b0100, 32'h00FF_0000);
    chk("R3 lane2 added", reg_rdata, 32'h003F_00FF);
    bus_write(4'b1010, 32'hFFFF_1F00);
    chk("R3 lane1 added", reg_rdata, 32'h003F_1FFF);
    bus_write(4'hF, 32'h0);
    chk("R3 cleared", reg_rdata, 32'h0);
    idle(2);
  endtask

  task automatic t_pulse(bit sec);
    string r = sec ? "R5" : "R4";
    logic [31:0] bitv = sec ? 32'h0002_0000 : 32'h0001_0000;
    bus_write(4'b0100, bitv);
    chk({r, " high before pulse"}, {31'd0, sec ? sec_serr_n : pri_serr_n}, 32'd1);
    @(negedge clk);
    chk({r, " pulse low"}, {31'd0, sec ? sec_serr_n : pri_serr_n}, 32'd0);
    chk({r, " other side high"}, {31'd0, sec ? pri_serr_n : sec_serr_n}, 32'd1);
    @(negedge clk);
    chk({r, " pulse ends"}, {31'd0, sec ? sec_serr_n : pri_serr_n}, 32'd1);
    // R6 rewrite while set: no pulse
    bus_write(4'b0100, bitv);
    for (int i = 0; i < 3; i++) begin
      chk("R6 locked out", {31'd0, sec ? sec_serr_n : pri_serr_n}, 32'd1);
      @(negedge clk);
    end
    bus_write(4'b0100, 32'h0);
    idle(1);
    bus_write(4'b0100, bitv);
    @(negedge clk);
    chk("R6 re-armed pulse", {31'd0, sec ? sec_serr_n : pri_serr_n}, 32'd0);
    @(negedge clk);
    chk("R6 re-armed pulse ends", {31'd0, sec ? sec_serr_n : pri_serr_n}, 32'd1);
    bus_write(4'b0100, 32'h0);
    idle(2);
  endtask

  task automatic remap_chk(string tag, logic [31:0] a, logic [31:0] e);
    ob_addr_in = a;
    #1;
    chk(tag, ob_addr_out, e);
  endtask

  task automatic t_remap();
    bus_write(4'hF, 32'h0004_0080);
    remap_chk("R7 low edge", 32'h0000_2000, 32'h8000_2000);
    remap_chk("R7 high edge", 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    remap_chk("R7 mid", 32'h1234_5678, 32'h9234_5678);
    remap_chk("R8 below window", 32'h0000_1FFF, 32'h0000_1FFF);
    remap_chk("R8 bit31 set", 32'h9000_0000, 32'h9000_0000);
    bus_write(4'hF, 32'h0004_0000);
    remap_chk("R8 dir off", 32'h0000_2000, 32'h0000_2000);
    bus_write(4'hF, 32'h0000_0080);
    remap_chk("R8 upper off", 32'h4000_0000, 32'h4000_0000);
    bus_write(4'hF, 32'h0);
  endtask

  task automatic match_chk(string tag, bit v, bit s, logic [3:0] c, logic [3:0] q,
                           bit ah, bit e);
    dr_valid = v; dr_side = s; dr_cur_cmd = c; dr_req_cmd = q; dr_addr_hit = ah;
    #1;
    chk(tag, {31'd0, dr_hit}, {31'd0, e});
  endtask

  task automatic t_match();
    match_chk("R9 exact equal", 1, 0, 4'h6, 4'h6, 1, 1);
    match_chk("R9 differ", 1, 0, 4'h7, 4'h6, 1, 0);
    match_chk("R9 addr miss", 1, 0, 4'h6, 4'h6, 0, 0);
    match_chk("R9 not valid", 0, 0, 4'h6, 4'h6, 1, 0);
    bus_write(4'hF, 32'h0008_0000);
    match_chk("R10 pri alias", 1, 0, 4'hE, 4'h6, 1, 1);
    match_chk("R10 sec not aliased", 1, 1, 4'hE, 4'h6, 1, 0);
    match_chk("R10 alias needs addr", 1, 0, 4'hE, 4'h6, 0, 0);
    bus_write(4'hF, 32'h0010_0000);
    match_chk("R10 sec alias", 1, 1, 4'hC, 4'h6, 1, 1);
    match_chk("R10 pri not aliased", 1, 0, 4'hC, 4'h6, 1, 0);
    bus_write(4'hF, 32'h0);
    dr_valid = 0; dr_addr_hit = 0;
  endtask

  task automatic t_status();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      tmr_expired = 3'(1 << i);
      @(negedge clk);
      tmr_expired = '0;
      chk("R11 set by timer", {31'd0, reg_rdata[15]}, 32'd1);
      @(negedge clk);
      chk("R11 sticky", {31'd0, reg_rdata[15]}, 32'd1);
      bus_write(4'b0010, 32'h0);
      chk("R12 write 0 keeps", {31'd0, reg_rdata[15]}, 32'd1);
      bus_write(4'b0010, 32'h0000_8000);
      chk("R12 write 1 clears", {31'd0, reg_rdata[15]}, 32'd0);
    end
    @(negedge clk);
    tmr_expired = 3'b001;
    @(negedge clk);
    tmr_expired = 3'b100;
    reg_wr_en = 1'b1; reg_be = 4'b0010; reg_wdata = 32'h0000_8000;
    @(negedge clk);
    tmr_expired = '0; reg_wr_en = 1'b0; reg_be = '0; reg_wdata = '0;
    chk("R12 expiry beats clear", {31'd0, reg_rdata[15]}, 32'd1);
    bus_write(4'b0010, 32'h0000_8000);
    chk("R12 final clear", {31'd0, reg_rdata[15]}, 32'd0);
  endtask

  task automatic t_fnswap();
    bus_write(4'b0100, 32'h0020_0000);
    chk("R13 fn_swap set", {31'd0, fn_swap}, 32'd1);
    chk("R13 bit21 readback", reg_rdata, 32'h0020_0000);
    bus_write(4'b0001, 32'h0000_0080);
    chk("R13 bit7 readback", reg_rdata, 32'h0020_0080);
    bus_write(4'hF, 32'h0);
    chk("R13 fn_swap clear", {31'd0, fn_swap}, 32'd0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_byte_en();
    t_pulse(1'b0);
    t_pulse(1'b1);
    t_remap();
    t_match();
    t_status();
    t_fnswap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule